// File: doc/BRIEF.md
# Conversion Readout Framer with Even Parity

The framer holds the most recent conversion result of a converter core (a data word, the channel it was taken on and an error flag) and sends it out one bit per shift strobe, most significant bit first. When the readout begins, the frame is built and copied into a shift register. From then on, conversions that arrive during the transfer update only the holding registers and never the bits being sent.

Two control inputs are sampled when the readout begins. The status-append control extends the frame from 24 to 32 bits by adding a status byte after the data word. The parity control makes that byte carry a bit that brings the count of ones across all 32 transmitted bits to an even number. A receiver that counts an odd number of ones knows the frame was damaged. A single parity bit cannot reveal an even number of flipped bits. Parity needs the status byte, so it has no effect on a 24-bit frame.

The control is a three-state machine. IDLE waits for a readout request. The transition start-accepted loads the frame and moves to SHIFT. SHIFT holds while no strobe arrives and moves one bit per strobe. The transition last-bit-shifted moves to DONE. DONE always returns to IDLE after one cycle through the transition done-return.

Top module: `readout_framer`

## Requirements
- R1: After reset the block is in IDLE: `busy`, `frame_done` and `sdo` are 0 and `rdy_n` is 1.
- R2: A cycle with `conv_valid` high stores the word, channel and error flag, and `rdy_n` is 0 from the next cycle.
- R3: `start` in IDLE with `append_status` low sends the 24-bit word, bit 23 first. `sdo` shows bit 23 in the cycle after `start` and moves one bit per cycle with `shift_en` high.
- R4: With `append_status` high the frame is 32 bits: the word, then the status byte from its bit 7 down to bit 0. The status byte is bit 7 = `rdy_n` as seen when the readout starts, bit 6 = error flag, bit 5 = 0, bit 4 = parity, bits 3..0 = channel.
- R5: With `append_status` and `parity_en` both high, status bit 4 is chosen so that the 32 transmitted bits contain an even number of ones (a word with 11 ones and an otherwise all-zero status byte gives bit 4 = 1).
- R6: With `parity_en` low, status bit 4 is sent as 0.
- R7: `parity_en` high with `append_status` low gives the plain 24-bit frame, with no parity bit added.
- R8: A conversion that arrives during SHIFT does not change any bit of the frame being sent.
- R9: `start` while SHIFT or DONE is ignored. With `shift_en` low in SHIFT, `sdo` holds its value.
- R10: After the strobe on the last bit, `frame_done` is high for exactly one cycle with `busy` low, and then the block returns to IDLE.
- R11: An accepted `start` sets `rdy_n` to 1, unless `conv_valid` is high in the same cycle, in which case `rdy_n` stays 0.
- R12: A readout repeated with no new conversion sends status bit 7 = 1, and parity (when enabled) accounts for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_valid | input | 1 | New conversion result present this cycle |
| conv_word | input | 24 | Conversion data word |
| conv_chan | input | 4 | Channel the conversion was taken on |
| conv_err | input | 1 | Error flag of the conversion |
| append_status | input | 1 | Add the status byte to the frame |
| parity_en | input | 1 | Fill the parity bit of the status byte |
| start | input | 1 | Begin a readout (accepted in IDLE only) |
| shift_en | input | 1 | Advance the frame by one bit |
| sdo | output | 1 | Serial data out, MSB first |
| busy | output | 1 | A frame is being shifted |
| frame_done | output | 1 | One-cycle pulse after the last bit |
| rdy_n | output | 1 | Low while an unread conversion is held |

## Verification
The assertions assume that `start`, `shift_en` and `conv_valid` are clean single-bit controls synchronous to `clk`. They also assume that `shift_en` has meaning only in SHIFT, so a strobe outside SHIFT must leave no trace. The stimulus drives every input half a cycle away from the sampling edge. It issues `start` only when the framer is IDLE, except in the cases that test `start` during SHIFT on purpose. It raises `shift_en` exactly as many times as the frame is long. The sweep covers all four control settings, all sixteen channels, both error states and data words chosen for different counts of ones. The late-conversion and mid-frame `start` cases are injected inside frames whose expected bits are already known.

// File: rtl/framer_pkg.sv
package framer_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_DONE  = 2'd2
    } fr_state_t;

    localparam int STAT_W   = 8;
    localparam int CHF_W    = 4;
    localparam int POS_RDY  = 7;
    localparam int POS_ERR  = 6;
    localparam int POS_RSV  = 5;
    localparam int POS_PAR  = 4;
endpackage

// File: rtl/result_hold.sv
module result_hold #(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_word,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_err,
    input  logic              take,
    output logic [DATA_W-1:0] hold_word,
    output logic [CHAN_W-1:0] hold_chan,
    output logic              hold_err,
    output logic              rdy_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_chan <= '0;
            hold_err  <= 1'b0;
            rdy_n     <= 1'b1;
        end else begin
            if (conv_valid) begin
                hold_word <= conv_word;
                hold_chan <= conv_chan;
                hold_err  <= conv_err;
                rdy_n     <= 1'b0;
            end else if (take) begin
                rdy_n     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import framer_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int CHAN_W  = 4,
    localparam int FRAME_W = DATA_W + STAT_W,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [CHAN_W-1:0]  chan,
    input  logic               err,
    input  logic               rdy_n,
    input  logic               append_status,
    input  logic               parity_en,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len_m1
);
    logic [STAT_W-1:0] stat_base;
    logic [STAT_W-1:0] stat_byte;
    logic              par_bit;

    always_comb begin
        stat_base          = '0;
        stat_base[POS_RDY] = rdy_n;
        stat_base[POS_ERR] = err;
        stat_base[POS_RSV] = 1'b0;
        stat_base[CHF_W-1:0] = CHF_W'(chan);
        par_bit   = (append_status && parity_en) ? ^{word, stat_base} : 1'b0;
        stat_byte = stat_base;
        stat_byte[POS_PAR] = par_bit;
        if (append_status) begin
            frame  = {word, stat_byte};
            len_m1 = CNT_W'(FRAME_W - 1);
        end else begin
            frame  = {word, {STAT_W{1'b0}}};
            len_m1 = CNT_W'(DATA_W - 1);
        end
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import framer_pkg::*;
#(
    parameter int FRAME_W = 32,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               shift_en,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   load_len_m1,
    output logic               take,
    output logic               sdo,
    output logic               busy,
    output logic               frame_done
);
    fr_state_t          state_q, state_d;
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SHIFT;
            S_SHIFT: if (shift_en && cnt_q == '0) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == S_IDLE && start) begin
            sreg_q <= load_frame;
            cnt_q  <= load_len_m1;
        end else if (state_q == S_SHIFT && shift_en) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        take       = 1'b0;
        sdo        = 1'b0;
        busy       = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            S_IDLE:  take = start;
            S_SHIFT: begin
                busy = 1'b1;
                sdo  = sreg_q[FRAME_W-1];
            end
            S_DONE:  frame_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/readout_framer.sv
module readout_framer
    import framer_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int CHAN_W  = 4,
    localparam int FRAME_W = DATA_W + STAT_W,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_word,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_err,
    input  logic              append_status,
    input  logic              parity_en,
    input  logic              start,
    input  logic              shift_en,
    output logic              sdo,
    output logic              busy,
    output logic              frame_done,
    output logic              rdy_n
);
    logic [DATA_W-1:0]  h_word;
    logic [CHAN_W-1:0]  h_chan;
    logic               h_err;
    logic               take;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len_m1;

    result_hold #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_word(conv_word), .conv_chan(conv_chan), .conv_err(conv_err),
        .take(take), .hold_word(h_word), .hold_chan(h_chan),
        .hold_err(h_err), .rdy_n(rdy_n)
    );

    frame_builder #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_build (
        .word(h_word), .chan(h_chan), .err(h_err), .rdy_n(rdy_n),
        .append_status(append_status), .parity_en(parity_en),
        .frame(frame), .len_m1(len_m1)
    );

    shift_unit #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .shift_en(shift_en),
        .load_frame(frame), .load_len_m1(len_m1), .take(take),
        .sdo(sdo), .busy(busy), .frame_done(frame_done)
    );
endmodule

// File: rtl/framer_checks.sv
module framer_checks (
    input logic clk,
    input logic rst_n,
    input logic conv_valid,
    input logic start,
    input logic shift_en,
    input logic sdo,
    input logic busy,
    input logic frame_done,
    input logic rdy_n
);
    logic idle;
    assign idle = !busy && !frame_done;

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> !rdy_n)
        else $error("p_capture_r2");

    p_begin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle) |=> busy)
        else $error("p_begin_r3");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en) |=> (busy && $stable(sdo)))
        else $error("p_hold_r9");

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy))
        else $error("p_done_pulse_r10");

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, frame_done}))
        else $error("p_excl_r10");

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && !conv_valid) |=> rdy_n)
        else $error("p_release_r11");
endmodule

bind readout_framer framer_checks u_chk (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .start(start),
    .shift_en(shift_en), .sdo(sdo), .busy(busy),
    .frame_done(frame_done), .rdy_n(rdy_n)
);

// File: tb/readout_framer_test.sv
module readout_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_word = '0;
    logic [3:0]  conv_chan = '0;
    logic        conv_err = 1'b0;
    logic        append_status = 1'b0;
    logic        parity_en = 1'b0;
    logic        start = 1'b0;
    logic        shift_en = 1'b0;
    logic        sdo, busy, frame_done, rdy_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    readout_framer uut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_word(conv_word), .conv_chan(conv_chan), .conv_err(conv_err),
        .append_status(append_status), .parity_en(parity_en),
        .start(start), .shift_en(shift_en), .sdo(sdo), .busy(busy),
        .frame_done(frame_done), .rdy_n(rdy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_frame(input logic [23:0] w, input logic [3:0] ch,
                                                 input logic er, input logic rd,
                                                 input logic app, input logic par);
        logic [7:0] st;
        int ones;
        ones = $countones(w) + $countones(ch) + int'(er) + int'(rd);
        st = {rd, er, 1'b0, (app && par) ? ((ones % 2) == 1) : 1'b0, ch};
        return app ? {w, st} : {8'h00, w};
    endfunction

    task automatic load_conv(input logic [23:0] w, input logic [3:0] ch, input logic er);
        @(negedge clk);
        conv_valid = 1'b1; conv_word = w; conv_chan = ch; conv_err = er;
        @(negedge clk);
        conv_valid = 1'b0;
        check("R2 rdy_n low after capture", {31'd0, rdy_n}, 32'd0);
    endtask

    // Reads one frame; inject=1 adds a late conversion and a stray start mid-frame.
    task automatic read_frame(input logic app, input logic par, input bit inject,
                              output logic [31:0] rx);
        int len;
        len = app ? 32 : 24;
        rx = '0;
        append_status = app; parity_en = par;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        append_status = ~app; parity_en = ~par;
        for (int i = 0; i < len; i++) begin
            rx = {rx[30:0], sdo};
            shift_en = 1'b1;
            if (inject && i == 5) start = 1'b1;
            if (inject && i == 10) begin
                conv_valid = 1'b1; conv_word = 24'h5A5A5A; conv_chan = 4'hF; conv_err = 1'b1;
            end
            if (inject && i == 3) begin
                shift_en = 1'b0;
                @(negedge clk);
                check("R9 sdo holds without strobe", {31'd0, sdo}, {31'd0, rx[0]});
                shift_en = 1'b1;
            end
            @(negedge clk);
            start = 1'b0; conv_valid = 1'b0;
        end
        shift_en = 1'b0;
        check("R10 done pulse after last bit", {30'd0, frame_done, busy}, 32'd2);
        @(negedge clk);
        check("R10 back to idle", {30'd0, frame_done, busy}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rx, ex;
        logic [23:0] words [4];
        words[0] = 24'h000000;
        words[1] = 24'h0007FF;   // eleven ones
        words[2] = 24'hFFFFFF;
        words[3] = 24'hA5C381;
        repeat (3) @(negedge clk);
        check("R1 reset state", {28'd0, busy, frame_done, sdo, rdy_n}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {28'd0, busy, frame_done, sdo, rdy_n}, 32'd1);

        // R5 example: eleven ones, channel 0, no error -> parity bit 1
        load_conv(24'h0007FF, 4'h0, 1'b0);
        read_frame(1'b1, 1'b1, 0, rx);
        check("R5 eleven-ones parity bit", {31'd0, rx[4]}, 32'd1);
        check("R11 rdy_n released by readout", {31'd0, rdy_n}, 32'd1);

        // Sweep: modes R3 R4 R5 R6 R7 over words, channels, error flag
        for (int m = 0; m < 4; m++) begin
            for (int wi = 0; wi < 4; wi++) begin
                for (int ch = 0; ch < 16; ch++) begin
                    for (int er = 0; er < 2; er++) begin
                        load_conv(words[wi] ^ 24'(ch * 24'h010203), 4'(ch), 1'(er));
                        ex = expect_frame(words[wi] ^ 24'(ch * 24'h010203), 4'(ch), 1'(er),
                                          1'b0, m[1], m[0]);
                        read_frame(m[1], m[0], 0, rx);
                        case (m)
                            0: check("R3 plain frame", rx, ex);
                            1: check("R7 parity without status", rx, ex);
                            2: check("R4 R6 status frame no parity", rx, ex);
                            default: begin
                                check("R4 R5 status frame with parity", rx, ex);
                                check("R5 even ones", {31'd0, 1'($countones(rx) % 2)}, 32'd0);
                            end
                        endcase
                    end
                end
            end
        end

        // R8 and R9: late conversion and stray start during the frame
        load_conv(24'h123456, 4'h3, 1'b0);
        ex = expect_frame(24'h123456, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1);
        read_frame(1'b1, 1'b1, 1, rx);
        check("R8 R9 frame unchanged by mid-frame events", rx, ex);
        check("R8 late conversion held as unread", {31'd0, rdy_n}, 32'd0);
        ex = expect_frame(24'h5A5A5A, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0);
        read_frame(1'b1, 1'b0, 0, rx);
        check("R8 late conversion sent next", rx, ex);

        // R12: repeat read with no new conversion
        ex = expect_frame(24'h5A5A5A, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1);
        read_frame(1'b1, 1'b1, 0, rx);
        check("R12 repeat read status bit7", rx, ex);
        check("R12 even ones", {31'd0, 1'($countones(rx) % 2)}, 32'd0);

        // R11: conversion coinciding with start keeps rdy_n low
        @(negedge clk);
        start = 1'b1; conv_valid = 1'b1; conv_word = 24'h00000F; conv_chan = 4'h1; conv_err = 1'b0;
        append_status = 1'b0; parity_en = 1'b0;
        @(negedge clk);
        start = 1'b0; conv_valid = 1'b0;
        check("R11 coincident conversion keeps rdy_n low", {31'd0, rdy_n}, 32'd0);
        check("R3 busy after start", {31'd0, busy}, 32'd1);
        for (int i = 0; i < 24; i++) begin
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        @(negedge clk);
        ex = expect_frame(24'h00000F, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0);
        read_frame(1'b0, 1'b0, 0, rx);
        check("R11 coincident conversion read next", rx, ex);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule